// File: doc/BRIEF.md
# Rotating Priority Resolver

This block chooses which interrupt line to present to the processor. It works for one eight-input controller stage. Each cycle it takes the pending request lines and removes the masked ones. It searches the remaining candidates starting at a movable rotation base, then compares the best candidate with the highest-priority line already in service. A candidate is presented only when it is strictly more urgent than every line in service. The result is a registered pending flag and the number of the winning line.

The block holds two pieces of state, the in-service vector and the rotation base. Both change when an acknowledge strobe arrives while a request is being presented. With automatic end-of-interrupt off, the acknowledged line is marked in service. With automatic end-of-interrupt on, no line is marked. If rotation on automatic end-of-interrupt is also on, the base moves to the line just after the acknowledged one. Separate load strobes let the surrounding command logic overwrite either piece of state, for example for end-of-interrupt or explicit rotation commands.

A build parameter marks the instance as the master stage. A master stage supports the mode that leaves the cascade line's in-service bit out of the comparison.

Top module: `rpr_top`

## Requirements
- R1: The priority of line n is (n - base) mod 8, with 0 the most urgent. Among the candidate lines, the one with the smallest priority value is chosen.
- R2: The candidate set is req_i AND NOT mask_i. A masked line is never reported. With an empty candidate set, irq_o is 0.
- R3: A candidate is reported only when its priority is strictly smaller than the smallest priority among the counted in-service bits. Otherwise irq_o is 0.
- R4: On a master instance with sfnm_i = 1, in-service bit 2 (the cascade line) is left out of the comparison in R3. With sfnm_i = 0, bit 2 counts like any other bit.
- R5: line_o equals (winning priority + base) mod 8 and is 0 whenever irq_o is 0. irq_o and line_o are registered. They reflect req_i, mask_i and sfnm_i as sampled at the previous clock edge, together with the in-service and base state held during that cycle.
- R6: An acknowledge (ack_i = 1 while irq_o = 1) with aeoi_i = 0 sets bit line_o of the in-service vector at that clock edge. The base is left unchanged.
- R7: An acknowledge with aeoi_i = 1 leaves the in-service vector unchanged. If rot_aeoi_i = 1, base becomes (line_o + 1) mod 8. If rot_aeoi_i = 0, the base is unchanged.
- R8: ack_i while irq_o = 0 changes neither the in-service vector nor the base.
- R9: isr_ld_i writes isr_wdata_i into the in-service vector, and base_ld_i writes base_wdata_i into the base. A load in the same cycle takes precedence over an acknowledge.
- R10: After reset, irq_o = 0, line_o = 0, the in-service vector is 0 and the base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request vector |
| mask_i | input | 8 | Mask vector; 1 blocks the line |
| aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| sfnm_i | input | 1 | Ignore the cascade line's in-service bit (master only) |
| ack_i | input | 1 | Acknowledge strobe |
| isr_ld_i | input | 1 | Load strobe for the in-service vector |
| isr_wdata_i | input | 8 | In-service load value |
| base_ld_i | input | 1 | Load strobe for the rotation base |
| base_wdata_i | input | 3 | Rotation base load value |
| irq_o | output | 1 | Registered pending flag |
| line_o | output | 3 | Registered winning line |
| isr_o | output | 8 | Current in-service vector |
| base_o | output | 3 | Current rotation base |

## Verification
Loads and acknowledges appear on isr_o and base_o one edge after they are driven. irq_o and line_o follow one edge later again, because they are computed from the state that has just been updated. The bench drives every stimulus on a falling edge. It reads the state ports at the next falling edge and the pending flag and line at the one after that, so each check lands in the cycle where its result is due. The expected winner is found by stepping the priority from 0 to 7 in the bench, which is a different method from the rotate-then-encode path in the design.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  // Acknowledge-time behaviour selected by the mode inputs.
  typedef enum logic [1:0] {
    ACK_MARK_SERVICE = 2'd0,  // set in-service bit
    ACK_AUTO_KEEP    = 2'd1,  // automatic EOI, base kept
    ACK_AUTO_ROTATE  = 2'd2   // automatic EOI, base moves past line
  } rpr_ack_kind_e;

  typedef struct packed {
    logic aeoi;
    logic rot_aeoi;
    logic sfnm;
  } rpr_mode_t;

  function automatic rpr_ack_kind_e ack_kind(input rpr_mode_t m);
    if (!m.aeoi)         return ACK_MARK_SERVICE;
    else if (m.rot_aeoi) return ACK_AUTO_ROTATE;
    else                 return ACK_AUTO_KEEP;
  endfunction

endpackage

// File: rtl/rpr_search.sv
// Finds the most urgent set bit of a vector measured from a base.
module rpr_search #(
  parameter int unsigned N_LINES = 8
) (
  input  logic [N_LINES-1:0]         vec_i,
  input  logic [$clog2(N_LINES)-1:0] base_i,
  output logic                       found_o,
  output logic [$clog2(N_LINES)-1:0] prio_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  // Entry i of the result is the line whose priority is i.
  function automatic logic [N_LINES-1:0] rotate_from(
    input logic [N_LINES-1:0] v,
    input logic [IW-1:0]      b
  );
    logic [N_LINES-1:0] r;
    logic [IW-1:0]      idx;
    for (int i = 0; i < N_LINES; i++) begin
      idx  = IW'(i) + b;
      r[i] = v[idx];
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] lowest_set(input logic [N_LINES-1:0] v);
    logic [IW-1:0] p;
    p = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (v[i]) p = IW'(i);
    end
    return p;
  endfunction

  logic [N_LINES-1:0] by_prio;

  always_comb begin
    by_prio = rotate_from(vec_i, base_i);
    found_o = |vec_i;
    prio_o  = lowest_set(by_prio);
  end

endmodule

// File: rtl/rpr_pick.sv
// Compares the best candidate against the in-service lines.
module rpr_pick #(
  parameter int unsigned N_LINES      = 8,
  parameter bit          IS_MASTER    = 1'b1,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic [N_LINES-1:0]         cand_i,
  input  logic [N_LINES-1:0]         isr_i,
  input  logic [$clog2(N_LINES)-1:0] base_i,
  input  logic                       sfnm_i,
  output logic                       win_o,
  output logic [$clog2(N_LINES)-1:0] line_o,
  output logic [N_LINES-1:0]         eff_isr_o
);
  localparam int unsigned IW = $clog2(N_LINES);
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASCADE_LINE;

  logic          cand_found, srv_found;
  logic [IW-1:0] cand_prio, srv_prio;

  generate
    if (IS_MASTER) begin : g_master
      assign eff_isr_o = sfnm_i ? (isr_i & ~CASC_BIT) : isr_i;
    end else begin : g_slave
      logic unused_sfnm;
      assign unused_sfnm = sfnm_i;
      assign eff_isr_o   = isr_i;
    end
  endgenerate

  rpr_search #(.N_LINES(N_LINES)) u_cand_search (
    .vec_i   (cand_i),
    .base_i  (base_i),
    .found_o (cand_found),
    .prio_o  (cand_prio)
  );

  rpr_search #(.N_LINES(N_LINES)) u_srv_search (
    .vec_i   (eff_isr_o),
    .base_i  (base_i),
    .found_o (srv_found),
    .prio_o  (srv_prio)
  );

  function automatic logic beats(
    input logic          c_found,
    input logic [IW-1:0] c_prio,
    input logic          s_found,
    input logic [IW-1:0] s_prio
  );
    return c_found && (!s_found || (c_prio < s_prio));
  endfunction

  function automatic logic [IW-1:0] prio_to_line(
    input logic [IW-1:0] p,
    input logic [IW-1:0] b
  );
    return p + b;
  endfunction

  always_comb begin
    win_o  = beats(cand_found, cand_prio, srv_found, srv_prio);
    line_o = prio_to_line(cand_prio, base_i);
  end

endmodule

// File: rtl/rpr_state.sv
// In-service vector and rotation base, updated by loads and acknowledges.
module rpr_state
  import rpr_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ack_i,
  input  logic                       irq_q_i,
  input  logic [$clog2(N_LINES)-1:0] line_q_i,
  input  rpr_mode_t                  mode_i,
  input  logic                       isr_ld_i,
  input  logic [N_LINES-1:0]         isr_wdata_i,
  input  logic                       base_ld_i,
  input  logic [$clog2(N_LINES)-1:0] base_wdata_i,
  output logic [N_LINES-1:0]         isr_q_o,
  output logic [$clog2(N_LINES)-1:0] base_q_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  function automatic logic [N_LINES-1:0] line_bit(input logic [IW-1:0] l);
    return N_LINES'(1) << l;
  endfunction

  function automatic logic [IW-1:0] base_after(input logic [IW-1:0] l);
    return l + IW'(1);
  endfunction

  // Named internal events for the assertions.
  logic          ack_take;
  rpr_ack_kind_e kind;
  logic          ev_mark;
  logic          ev_rotate;

  assign ack_take  = ack_i && irq_q_i;
  assign kind      = ack_kind(mode_i);
  assign ev_mark   = ack_take && (kind == ACK_MARK_SERVICE);
  assign ev_rotate = ack_take && (kind == ACK_AUTO_ROTATE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q_o  <= '0;
      base_q_o <= '0;
    end else begin
      if (isr_ld_i)     isr_q_o <= isr_wdata_i;
      else if (ev_mark) isr_q_o <= isr_q_o | line_bit(line_q_i);

      if (base_ld_i)      base_q_o <= base_wdata_i;
      else if (ev_rotate) base_q_o <= base_after(line_q_i);
    end
  end

  AST_ACK_MARKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_q_i && !mode_i.aeoi && !isr_ld_i && !base_ld_i)
      |=> ((isr_q_o & line_bit($past(line_q_i))) != '0) && $stable(base_q_o)); // R6

  AST_AUTO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_q_i && mode_i.aeoi && !isr_ld_i) |=> $stable(isr_q_o)); // R7

  AST_AUTO_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_q_i && mode_i.aeoi && mode_i.rot_aeoi && !base_ld_i)
      |=> (base_q_o == base_after($past(line_q_i)))); // R7

  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_q_i && !isr_ld_i && !base_ld_i)
      |=> ($stable(isr_q_o) && $stable(base_q_o))); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    isr_ld_i |=> (isr_q_o == $past(isr_wdata_i))); // R9

endmodule

// File: rtl/rpr_top.sv
module rpr_top
  import rpr_pkg::*;
#(
  parameter int unsigned N_LINES      = 8,
  parameter bit          IS_MASTER    = 1'b1,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         req_i,
  input  logic [N_LINES-1:0]         mask_i,
  input  logic                       aeoi_i,
  input  logic                       rot_aeoi_i,
  input  logic                       sfnm_i,
  input  logic                       ack_i,
  input  logic                       isr_ld_i,
  input  logic [N_LINES-1:0]         isr_wdata_i,
  input  logic                       base_ld_i,
  input  logic [$clog2(N_LINES)-1:0] base_wdata_i,
  output logic                       irq_o,
  output logic [$clog2(N_LINES)-1:0] line_o,
  output logic [N_LINES-1:0]         isr_o,
  output logic [$clog2(N_LINES)-1:0] base_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] eff_isr;
  logic               win;
  logic [IW-1:0]      win_line;
  logic               irq_q;
  logic [IW-1:0]      line_q;
  logic [N_LINES-1:0] isr_q;
  logic [IW-1:0]      base_q;
  rpr_mode_t          mode;

  assign cand = req_i & ~mask_i;
  assign mode = '{aeoi: aeoi_i, rot_aeoi: rot_aeoi_i, sfnm: sfnm_i};

  rpr_pick #(
    .N_LINES      (N_LINES),
    .IS_MASTER    (IS_MASTER),
    .CASCADE_LINE (CASCADE_LINE)
  ) u_pick (
    .cand_i    (cand),
    .isr_i     (isr_q),
    .base_i    (base_q),
    .sfnm_i    (mode.sfnm),
    .win_o     (win),
    .line_o    (win_line),
    .eff_isr_o (eff_isr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      line_q <= '0;
    end else begin
      irq_q  <= win;
      line_q <= win ? win_line : '0;
    end
  end

  rpr_state #(.N_LINES(N_LINES)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .irq_q_i      (irq_q),
    .line_q_i     (line_q),
    .mode_i       (mode),
    .isr_ld_i     (isr_ld_i),
    .isr_wdata_i  (isr_wdata_i),
    .base_ld_i    (base_ld_i),
    .base_wdata_i (base_wdata_i),
    .isr_q_o      (isr_q),
    .base_q_o     (base_q)
  );

  assign irq_o  = irq_q;
  assign line_o = line_q;
  assign isr_o  = isr_q;
  assign base_o = base_q;

  AST_WINNER_WAS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((($past(cand) >> line_q) & N_LINES'(1)) != '0)); // R2

  AST_WINNER_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((($past(eff_isr) >> line_q) & N_LINES'(1)) == '0)); // R3

  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(win)) |-> (!irq_q && (line_q == '0))); // R5

endmodule

// File: tb/rpr_top_tb.sv
module rpr_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, isr_wd = '0;
  logic       aeoi = 1'b0, rot = 1'b0, sfnm = 1'b0, ack = 1'b0;
  logic       isr_ld = 1'b0, base_ld = 1'b0;
  logic [2:0] base_wd = '0;
  logic       irq;
  logic [2:0] line, base_o;
  logic [7:0] isr_o;

  int n_chk = 0;
  int n_bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  rpr_top u_dut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .mask_i (mask),
    .aeoi_i (aeoi), .rot_aeoi_i (rot), .sfnm_i (sfnm), .ack_i (ack),
    .isr_ld_i (isr_ld), .isr_wdata_i (isr_wd), .base_ld_i (base_ld),
    .base_wdata_i (base_wd), .irq_o (irq), .line_o (line),
    .isr_o (isr_o), .base_o (base_o)
  );

  function automatic int unsigned next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // Reference: step the priority value upward from 0.
  function automatic int best_prio(input logic [7:0] v, input int b);
    for (int p = 0; p < 8; p++) if (v[(b + p) % 8]) return p;
    return 8;
  endfunction

  task automatic expect_out(input logic [7:0] r, input logic [7:0] m,
                            input logic [7:0] s, input int b, input bit nest,
                            output bit e_irq, output int e_line);
    logic [7:0] eff;
    int cp, sp;
    eff = s;
    if (nest) eff[2] = 1'b0;
    cp = best_prio(r & ~m, b);
    sp = best_prio(eff, b);
    e_irq  = (cp < 8) && (cp < sp);
    e_line = e_irq ? (cp + b) % 8 : 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Load state and inputs, then check the registered outputs when due.
  task automatic apply(input logic [7:0] r, input logic [7:0] m,
                       input logic [7:0] s, input int b, input bit nest,
                       input string tag);
    bit e_irq;
    int e_line;
    @(negedge clk);
    req = r; mask = m; sfnm = nest;
    isr_ld = 1'b1; isr_wd = s; base_ld = 1'b1; base_wd = 3'(b);
    @(negedge clk);
    isr_ld = 1'b0; base_ld = 1'b0;
    @(negedge clk);
    expect_out(r, m, s, b, nest, e_irq, e_line);
    chk(irq == e_irq, {tag, " irq"}, irq, e_irq);
    chk(int'(line) == e_line, {tag, " line"}, line, e_line);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(irq == 1'b0, "R10 irq", irq, 0);
    chk(line == 3'd0, "R10 line", line, 0);
    chk(isr_o == 8'h00, "R10 isr", isr_o, 0);
    chk(base_o == 3'd0, "R10 base", base_o, 0);

    // Directed corners
    apply(8'h00, 8'h00, 8'h00, 0, 1'b0, "R2 empty");
    apply(8'h30, 8'h10, 8'h00, 0, 1'b0, "R2 masked");
    apply(8'h81, 8'h00, 8'h00, 7, 1'b0, "R1 base7");
    apply(8'h08, 8'h00, 8'h08, 0, 1'b0, "R3 equal");
    apply(8'h10, 8'h00, 8'h08, 0, 1'b0, "R3 lower");
    apply(8'h02, 8'h00, 8'h08, 0, 1'b0, "R3 higher");
    apply(8'h08, 8'h00, 8'h04, 0, 1'b1, "R4 nested on");
    apply(8'h08, 8'h00, 8'h04, 0, 1'b0, "R4 nested off");
    apply(8'h04, 8'h00, 8'h04, 0, 1'b1, "R4 cascade again");

    // Sweep: every base, both nesting settings, pseudo-random vectors
    for (int nest = 0; nest < 2; nest++)
      for (int b = 0; b < 8; b++)
        for (int k = 0; k < 40; k++) begin
          logic [7:0] r, m, s;
          r = 8'(next_rand());
          m = 8'(next_rand()) & 8'(next_rand());
          s = (k % 4 == 0) ? 8'h00 : (8'(next_rand()) & 8'(next_rand()));
          apply(r, m, s, b, nest[0], "R1 R5 sweep");
        end

    // Acknowledge sweep over base and mode
    for (int b = 0; b < 8; b++)
      for (int md = 0; md < 3; md++) begin
        logic [7:0] r;
        bit e_irq;
        int e_line;
        logic [7:0] e_isr;
        int e_base;
        r = 8'(next_rand()) | (8'h1 << (next_rand() % 8));
        aeoi = (md != 0); rot = (md == 2);
        apply(r, 8'h00, 8'h00, b, 1'b0, "R6 R7 setup");
        expect_out(r, 8'h00, 8'h00, b, 1'b0, e_irq, e_line);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        e_isr  = (md == 0) ? (8'h1 << e_line) : 8'h00;
        e_base = (md == 2) ? (e_line + 1) % 8 : b;
        chk(isr_o == e_isr, (md == 0) ? "R6 isr" : "R7 isr", isr_o, e_isr);
        chk(int'(base_o) == e_base, (md == 2) ? "R7 base rotate" : "R6 R7 base kept",
            base_o, e_base);
        @(negedge clk);
        expect_out(r, 8'h00, e_isr, e_base, 1'b0, e_irq, e_line);
        chk(irq == e_irq, "R3 after ack irq", irq, e_irq);
        chk(int'(line) == e_line, "R3 after ack line", line, e_line);
      end
    aeoi = 1'b0; rot = 1'b0;

    // R8 acknowledge while idle
    apply(8'h00, 8'h00, 8'h22, 5, 1'b0, "R8 setup");
    aeoi = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(isr_o == 8'h22, "R8 isr", isr_o, 8'h22);
    chk(base_o == 3'd5, "R8 base", base_o, 5);
    aeoi = 1'b1; rot = 1'b1;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(base_o == 3'd5, "R8 base auto", base_o, 5);
    aeoi = 1'b0; rot = 1'b0;

    // R9 load beats acknowledge
    apply(8'h40, 8'h00, 8'h00, 0, 1'b0, "R9 setup");
    ack = 1'b1; isr_ld = 1'b1; isr_wd = 8'h81;
    @(negedge clk);
    ack = 1'b0; isr_ld = 1'b0;
    chk(isr_o == 8'h81, "R9 isr load", isr_o, 8'h81);
    aeoi = 1'b1; rot = 1'b1;
    ack = 1'b1; base_ld = 1'b1; base_wd = 3'd3;
    @(negedge clk);
    ack = 1'b0; base_ld = 1'b0; aeoi = 1'b0; rot = 1'b0;
    chk(base_o == 3'd3, "R9 base load", base_o, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule